// File: doc/BRIEF.md
# Variable-Prefix Run-Length Scan Decompressor

This block expands a serial stream of compressed test data into the bit sequence for a scan chain. Each codeword starts with a run-type bit. A variable-length group prefix follows, and then a tail of the same size as the group. The decoder rebuilds a run length `L` from the prefix and the tail. It then emits `L` copies of the run-type value, followed by one complemented terminating bit. It emits one bit per cycle on `scan_o`, with `scan_vld_o` high.

The decoder asks for compressed bits with `en_o` and takes a bit only in a cycle where the source also asserts `bit_vld_i`. A small counter measures the prefix length, which gives the group number `m`. The same counter then counts down the `m` tail bits. A shift register, seeded from the prefix polarity, collects the tail. Its final value loads a down-counter that paces the run. A toggle flop XORed with the stored run-type bit sets the polarity of each output bit. The deepest group accepted is set by `MAX_GRP`. A longer prefix raises a sticky error and the decoder returns to reading a run-type bit.

Top module: `vprl_decoder`

## Requirements
- R1: After reset is released, `en_o` is 1, `scan_vld_o` is 0 and `err_o` is 0.
- R2: An input bit is consumed only on a rising clock edge where both `en_o` and `bit_vld_i` are 1. `en_o` is 0 in every cycle where `scan_vld_o` is 1. Idle cycles on `bit_vld_i` do not change the decoded output.
- R3: A codeword is, in order: the run-type bit `a`; a prefix of `m` equal bits (1 <= m <= MAX_GRP) closed by one bit of the opposite value; then `m` tail bits, most significant first. A prefix of 0s is the plain form and a prefix of 1s is the inverted form.
- R4: The run length is `L = 2^(m+1) - 3 + (inverted form ? 2^m : 0) + tail`. The decoder produces exactly `L+1` valid output bits per codeword.
- R5: The output for a codeword is `L` bits equal to `a`, then one bit equal to `~a`. These bits come in consecutive cycles, with `scan_vld_o` high for exactly those cycles.
- R6: The codewords 0|010, 0|100, 1|011, 1|101 (run type | prefix+tail) produce the output `01000111011110`.
- R7: If the prefix reaches `MAX_GRP+1` equal bits, `err_o` is set, no output is produced for that codeword, and the next input bit is taken as a new run-type bit.
- R8: `err_o` stays high until reset and is never set by well-formed codewords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Compressed stream bit |
| bit_vld_i | input | 1 | `bit_i` holds a valid bit |
| en_o | output | 1 | Decoder is ready to take an input bit |
| scan_o | output | 1 | Decompressed scan-in bit |
| scan_vld_o | output | 1 | `scan_o` carries a real bit |
| err_o | output | 1 | Sticky error: prefix too long |

## Verification
The assertions check four things in every cycle:
- the input request and the output strobe are never high together;
- the error flag never falls;
- the error flag never rises while a run is being emitted;
- every burst of valid output ends with a bit that differs from the bit before it.

Only the bench scenarios can show that the run length and the run-type value match the formula. The bench covers every run length of a small configuration, in both polarities, with and without idle input cycles. It also runs the worked example sequence and overlong prefixes of both forms, each followed by a recovery codeword.

// File: rtl/vprl_pkg.sv
package vprl_pkg;
  typedef enum logic [2:0] {
    ST_TYPE,
    ST_PFX0,
    ST_PFX,
    ST_TAIL,
    ST_RUN,
    ST_TERM
  } vprl_state_e;
endpackage

// File: rtl/vprl_grp_cnt.sv
// Prefix/tail counter: counts prefix length up, then tail bits down.
module vprl_grp_cnt #(
  parameter int GW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [GW-1:0] cnt_o
);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (set_i) cnt_q <= GW'(1);
    else if (inc_i) cnt_q <= cnt_q + GW'(1);
    else if (dec_i) cnt_q <= cnt_q - GW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vprl_len_cnt.sv
// Tail shift register seeded by prefix polarity, then the run-length down-counter.
module vprl_len_cnt #(
  parameter int LW = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic seed_i,
  input  logic seed_inv_i,
  input  logic shift_i,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  logic [LW-2:0] acc_q;
  logic [LW-1:0] full;
  logic [LW-1:0] cnt_q;

  // {acc, new bit} = (2 + inv) * 2^m + tail
  assign full = {acc_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (seed_i)  acc_q <= (LW-1)'({1'b1, seed_inv_i});
    else if (shift_i) acc_q <= full[LW-2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= full - LW'(3);
    else if (dec_i)  cnt_q <= cnt_q - LW'(1);
  end

  assign last_o = (cnt_q == LW'(1));
endmodule

// File: rtl/vprl_polarity.sv
// Run-type register and toggle flop; XOR gives the scan-in bit.
module vprl_polarity (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic type_ld_i,
  input  logic tog_i,
  output logic scan_o
);
  logic type_q;
  logic tff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        type_q <= 1'b0;
    else if (type_ld_i) type_q <= bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tff_q <= 1'b0;
    else if (tog_i) tff_q <= ~tff_q;
  end

  assign scan_o = tff_q ^ type_q;
endmodule

// File: rtl/vprl_fsm.sv
module vprl_fsm
  import vprl_pkg::*;
#(
  parameter int MAX_GRP = 8,
  parameter int GW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic          bit_vld_i,
  input  logic [GW-1:0] grp_cnt_i,
  input  logic          len_last_i,
  output logic          en_o,
  output logic          type_ld_o,
  output logic          grp_set_o,
  output logic          grp_inc_o,
  output logic          grp_dec_o,
  output logic          seed_o,
  output logic          seed_inv_o,
  output logic          shift_o,
  output logic          len_load_o,
  output logic          len_dec_o,
  output logic          tog_o,
  output logic          vld_o,
  output logic          err_o
);
  vprl_state_e st_q, st_d;
  logic        pfx_q;
  logic        err_q, err_set;
  logic        take;

  assign en_o = (st_q == ST_TYPE) || (st_q == ST_PFX0) ||
                (st_q == ST_PFX)  || (st_q == ST_TAIL);
  assign take = en_o && bit_vld_i;

  always_comb begin
    st_d       = st_q;
    type_ld_o  = 1'b0;
    grp_set_o  = 1'b0;
    grp_inc_o  = 1'b0;
    grp_dec_o  = 1'b0;
    seed_o     = 1'b0;
    shift_o    = 1'b0;
    len_load_o = 1'b0;
    len_dec_o  = 1'b0;
    tog_o      = 1'b0;
    vld_o      = 1'b0;
    err_set    = 1'b0;
    unique case (st_q)
      ST_TYPE: if (take) begin
        type_ld_o = 1'b1;
        st_d      = ST_PFX0;
      end
      ST_PFX0: if (take) begin
        grp_set_o = 1'b1;
        st_d      = ST_PFX;
      end
      ST_PFX: if (take) begin
        if (bit_i == pfx_q) begin
          if (grp_cnt_i == GW'(MAX_GRP)) begin
            err_set = 1'b1;
            st_d    = ST_TYPE;
          end else begin
            grp_inc_o = 1'b1;
          end
        end else begin
          seed_o = 1'b1;
          st_d   = ST_TAIL;
        end
      end
      ST_TAIL: if (take) begin
        shift_o   = 1'b1;
        grp_dec_o = 1'b1;
        if (grp_cnt_i == GW'(1)) begin
          len_load_o = 1'b1;
          st_d       = ST_RUN;
        end
      end
      ST_RUN: begin
        vld_o     = 1'b1;
        len_dec_o = 1'b1;
        if (len_last_i) begin
          tog_o = 1'b1;
          st_d  = ST_TERM;
        end
      end
      ST_TERM: begin
        vld_o = 1'b1;
        tog_o = 1'b1;
        st_d  = ST_TYPE;
      end
      default: st_d = ST_TYPE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_TYPE;
      pfx_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_PFX0 && take) pfx_q <= bit_i;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign seed_inv_o = pfx_q;
  assign err_o      = err_q;
endmodule

// File: rtl/vprl_decoder.sv
module vprl_decoder #(
  parameter int MAX_GRP = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic en_o,
  output logic scan_o,
  output logic scan_vld_o,
  output logic err_o
);
  localparam int GW = $clog2(MAX_GRP + 1);
  localparam int LW = MAX_GRP + 2;

  logic [GW-1:0] grp_cnt;
  logic type_ld, grp_set, grp_inc, grp_dec;
  logic seed, seed_inv, shift, len_load, len_dec, len_last, tog;

  vprl_fsm #(.MAX_GRP(MAX_GRP), .GW(GW)) u_fsm (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i,
    .grp_cnt_i (grp_cnt),
    .len_last_i(len_last),
    .en_o,
    .type_ld_o (type_ld),
    .grp_set_o (grp_set),
    .grp_inc_o (grp_inc),
    .grp_dec_o (grp_dec),
    .seed_o    (seed),
    .seed_inv_o(seed_inv),
    .shift_o   (shift),
    .len_load_o(len_load),
    .len_dec_o (len_dec),
    .tog_o     (tog),
    .vld_o     (scan_vld_o),
    .err_o
  );

  vprl_grp_cnt #(.GW(GW)) u_grp (
    .clk_i, .rst_ni,
    .set_i(grp_set), .inc_i(grp_inc), .dec_i(grp_dec),
    .cnt_o(grp_cnt)
  );

  vprl_len_cnt #(.LW(LW)) u_len (
    .clk_i, .rst_ni, .bit_i,
    .seed_i(seed), .seed_inv_i(seed_inv), .shift_i(shift),
    .load_i(len_load), .dec_i(len_dec),
    .last_o(len_last)
  );

  vprl_polarity u_pol (
    .clk_i, .rst_ni, .bit_i,
    .type_ld_i(type_ld), .tog_i(tog),
    .scan_o
  );
endmodule

// File: rtl/vprl_decoder_chk.sv
module vprl_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_o,
  input logic scan_o,
  input logic scan_vld_o,
  input logic err_o
);
  // R2
  req_vs_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_o && scan_vld_o));

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R7
  err_no_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !scan_vld_o);

  // R5
  term_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_vld_o && $past(scan_vld_o)) |-> ($past(scan_o) != $past(scan_o, 2)));
endmodule

bind vprl_decoder vprl_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_o(en_o),
  .scan_o(scan_o), .scan_vld_o(scan_vld_o), .err_o(err_o)
);

// File: tb/vprl_decoder_tb.sv
module vprl_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MG = 3;
  localparam int LMAX = (1 << (MG + 2)) - 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic en, scan, scan_vld, err;

  int checks = 0;
  int errors = 0;
  int out_cnt = 0;
  string tag = "R5";
  bit expq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  vprl_decoder #(.MAX_GRP(MG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_vld_i(bit_vld),
    .en_o(en), .scan_o(scan), .scan_vld_o(scan_vld), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && scan_vld) begin
      out_cnt++;
      chk(!en, "R2 en_o with output", int'(en), 0);
      if (expq.size() == 0) chk(1'b0, {tag, " unexpected bit"}, int'(scan), -1);
      else begin
        bit e;
        e = expq.pop_front();
        chk(scan == e, tag, int'(scan), int'(e));
      end
    end
  end

  task automatic send_bit(input bit b, input int gap);
    repeat (gap) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in  = ~b;
    end
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    while (!en) @(negedge clk);
    @(posedge clk);
    #1;
    bit_vld = 1'b0;
  endtask

  task automatic send_code(input bit a, input int len, input int gap);
    int m, base, half, tl;
    bit inv;
    m = 1;
    while (len > (1 << (m + 2)) - 4) m++;
    base = (1 << (m + 1)) - 3;
    half = 1 << m;
    inv  = (len - base) >= half;
    tl   = len - base - (inv ? half : 0);
    for (int i = 0; i < len; i++) expq.push_back(a);
    expq.push_back(~a);
    send_bit(a, gap);
    for (int i = 0; i < m; i++) send_bit(inv, gap);
    send_bit(~inv, gap);
    for (int i = m - 1; i >= 0; i--) send_bit(tl[i], gap);
  endtask

  task automatic settle(input int len);
    repeat (len + 3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(en == 1'b1, "R1 en_o", int'(en), 1);
    chk(scan_vld == 1'b0, "R1 scan_vld_o", int'(scan_vld), 0);
    chk(err == 1'b0, "R1 err_o", int'(err), 0);

    // R3 R4 R5: every length, both run types, back-to-back input
    tag = "R3 R5";
    for (int a = 0; a < 2; a++) begin
      for (int len = 1; len <= LMAX; len++) begin
        c0 = out_cnt;
        send_code(bit'(a), len, 0);
        settle(len);
        chk(out_cnt - c0 == len + 1, "R4 count", out_cnt - c0, len + 1);
        chk(expq.size() == 0, "R4 drained", expq.size(), 0);
      end
    end

    // R2: idle cycles between input bits
    tag = "R2";
    for (int len = 1; len <= LMAX; len += 3) begin
      c0 = out_cnt;
      send_code(bit'(len & 1), len, 1 + (len % 3));
      settle(len);
      chk(out_cnt - c0 == len + 1, "R2 count", out_cnt - c0, len + 1);
    end
    chk(err == 1'b0, "R8 no err on valid codes", int'(err), 0);

    // R6: worked example, codewords streamed without waiting
    tag = "R6";
    c0 = out_cnt;
    send_code(1'b0, 1, 0);
    send_code(1'b0, 3, 0);
    send_code(1'b1, 2, 0);
    send_code(1'b1, 4, 0);
    settle(6);
    chk(out_cnt - c0 == 14, "R6 count", out_cnt - c0, 14);
    chk(expq.size() == 0, "R6 drained", expq.size(), 0);

    // R7: overlong plain prefix
    tag = "R7";
    c0 = out_cnt;
    send_bit(1'b0, 0);
    for (int i = 0; i < MG + 1; i++) send_bit(1'b0, 0);
    repeat (2) @(negedge clk);
    chk(err == 1'b1, "R7 err set", int'(err), 1);
    chk(out_cnt == c0, "R7 no output", out_cnt - c0, 0);
    chk(en == 1'b1, "R7 ready again", int'(en), 1);
    send_code(1'b1, 5, 0);
    settle(5);
    chk(out_cnt - c0 == 6, "R7 recovery count", out_cnt - c0, 6);

    // R7 R8: overlong inverted prefix, flag stays set
    c0 = out_cnt;
    send_bit(1'b1, 0);
    for (int i = 0; i < MG + 1; i++) send_bit(1'b1, 0);
    repeat (2) @(negedge clk);
    chk(out_cnt == c0, "R7 no output inv", out_cnt - c0, 0);
    send_code(1'b0, 9, 0);
    settle(9);
    chk(out_cnt - c0 == 10, "R7 recovery count inv", out_cnt - c0, 10);
    chk(err == 1'b1, "R8 err sticky", int'(err), 1);
    chk(expq.size() == 0, "R7 drained", expq.size(), 0);

    summary();
  end
endmodule